// File: doc/BRIEF.md
# Dual-Issue Pipeline Interlock Unit

This block makes the issue decision for an in-order pipeline that can start two instructions per cycle. Every cycle the front end presents a pair of decoded instructions: the older one and the younger one. Each instruction names up to two source registers, one destination register, whether it reads or writes the condition flag, and a two-bit latency class. The block answers with one issue enable per slot and a stall indicator. The front end then moves forward by the number of instructions issued. A younger instruction that is held back moves into the older slot on the next cycle, so program order is kept.

A scoreboard holds one countdown for each of the sixteen general registers and one for the flag. When an instruction issues, its destination countdowns are loaded from its latency class. Every countdown then drops by one per cycle until it reaches zero. Any instruction that reads or writes a non-zero entry is held. Inside a pair, the younger instruction is held when it reads the older one's result, unless the older one is a zero-latency instruction. The older instruction never waits for the younger.

Top module: `dual_issue_interlock`

## Requirements
- R1: While the synchronous active-high reset is high, neither issue enable is asserted. On the edge where reset is sampled high, every countdown clears, so the first pair after reset sees every register and the flag as ready.
- R2: Latency class encoding: 0 = zero-latency, 1 = one cycle, 2 = load, 3 = multiply or FPU. A consumer of a result from a class-c instruction that issued in cycle t may issue no earlier than cycle t + max(c, 1).
- R3: An instruction is held while one of its enabled register sources (index 0 to 15) or its flag read refers to an entry whose countdown is non-zero.
- R4: An instruction is held while its enabled destination register, or the flag it writes, has a non-zero countdown. This prevents a short result from overtaking a long one to the same place.
- R5: When the older instruction is not issued, the younger one is not issued either.
- R6: When only the younger instruction has a conflict, the older instruction issues alone.
- R7: The younger instruction is held when the older instruction has a non-zero latency class and the younger reads the older's enabled destination register or the flag the older writes.
- R8: When the older instruction has latency class 0, a younger instruction that reads its destination register or flag issues in the same cycle. Examples are a flag-setting compare followed by a conditional branch, and a register move followed by an add that reads the moved register.
- R9: A slot whose valid input is low never issues. The younger slot issues only in a cycle in which the older slot issues.
- R10: The stall output is high exactly when some valid slot is not issued in that cycle.
- R11: When both instructions of an issued pair write the same register or the flag, that entry takes the younger instruction's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| old_valid | input | 1 | Older slot holds an instruction |
| old_src_a | input | 4 | Older first source register |
| old_src_a_en | input | 1 | Older first source is read |
| old_src_b | input | 4 | Older second source register |
| old_src_b_en | input | 1 | Older second source is read |
| old_dst | input | 4 | Older destination register |
| old_dst_en | input | 1 | Older writes its destination |
| old_flag_rd | input | 1 | Older reads the flag |
| old_flag_wr | input | 1 | Older writes the flag |
| old_lat | input | 2 | Older latency class |
| yng_valid | input | 1 | Younger slot holds an instruction |
| yng_src_a | input | 4 | Younger first source register |
| yng_src_a_en | input | 1 | Younger first source is read |
| yng_src_b | input | 4 | Younger second source register |
| yng_src_b_en | input | 1 | Younger second source is read |
| yng_dst | input | 4 | Younger destination register |
| yng_dst_en | input | 1 | Younger writes its destination |
| yng_flag_rd | input | 1 | Younger reads the flag |
| yng_flag_wr | input | 1 | Younger writes the flag |
| yng_lat | input | 2 | Younger latency class |
| old_issue | output | 1 | Older instruction issues this cycle |
| yng_issue | output | 1 | Younger instruction issues this cycle |
| stall | output | 1 | A valid slot is held this cycle |

## Verification
The hardest case to reach is a younger instruction that is held while the older one issues. It needs a scoreboard history in which exactly the younger instruction's operands are still pending. Same-destination pairs are also hard to reach, because their effect only shows up one cycle later in whether a reader of that register issues. The bench models the front end. Held younger instructions shift into the older slot, and the bench streams fixed programs through the block: load-use chains, compare-branch pairs, move-add pairs, multiply chains, independent work, same-destination triples and hashed random operands over four registers. Bubbles in both slots and a reset in the middle of each run place these cases on top of many different countdown states.

// File: rtl/dii_pkg.sv
package dii_pkg;

    localparam int CNT_W = 2;

    typedef enum logic [1:0] {
        LAT_ZERO = 2'd0,
        LAT_ONE  = 2'd1,
        LAT_LOAD = 2'd2,
        LAT_LONG = 2'd3
    } lat_e;

    // Countdown seeded at issue: a consumer becomes ready max(class,1) cycles later.
    function automatic logic [CNT_W-1:0] lat_seed(input logic [1:0] cls);
        logic [CNT_W-1:0] s;
        if (lat_e'(cls) == LAT_ZERO) s = '0;
        else                         s = CNT_W'(cls - 2'd1);
        return s;
    endfunction

endpackage

// File: rtl/dii_scoreboard.sv
module dii_scoreboard
    import dii_pkg::*;
#(
    parameter int NENT = 17
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NENT-1:0] wr_old_mask,
    input  logic [1:0]      wr_old_lat,
    input  logic [NENT-1:0] wr_yng_mask,
    input  logic [1:0]      wr_yng_lat,
    output logic [NENT-1:0] busy
);

    typedef struct packed {
        logic [NENT-1:0][CNT_W-1:0] cnt;
    } sb_state_t;

    sb_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < NENT; e++) begin
            if (rst) begin
                st_d.cnt[e] = '0;
            end else if (wr_yng_mask[e]) begin
                st_d.cnt[e] = lat_seed(wr_yng_lat);
            end else if (wr_old_mask[e]) begin
                st_d.cnt[e] = lat_seed(wr_old_lat);
            end else if (st_q.cnt[e] != '0) begin
                st_d.cnt[e] = st_q.cnt[e] - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar e = 0; e < NENT; e++) begin : g_busy
        assign busy[e] = (st_q.cnt[e] != '0);
    end

endmodule

// File: rtl/dii_slot_hazard.sv
module dii_slot_hazard #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = $clog2(NUM_REGS),
    parameter int NENT     = NUM_REGS + 1
) (
    input  logic             src_a_en,
    input  logic [REG_W-1:0] src_a,
    input  logic             src_b_en,
    input  logic [REG_W-1:0] src_b,
    input  logic             dst_en,
    input  logic [REG_W-1:0] dst,
    input  logic             flag_rd,
    input  logic             flag_wr,
    input  logic [NENT-1:0]  busy,
    output logic             hazard
);

    localparam int FLAG_IDX = NUM_REGS;

    logic raw_hit;
    logic waw_hit;

    always_comb begin
        raw_hit = (src_a_en && busy[src_a])
               || (src_b_en && busy[src_b])
               || (flag_rd  && busy[FLAG_IDX]);
        waw_hit = (dst_en  && busy[dst])
               || (flag_wr && busy[FLAG_IDX]);
        hazard  = raw_hit || waw_hit;
    end

endmodule

// File: rtl/dii_pair_check.sv
module dii_pair_check #(
    parameter int REG_W = 4
) (
    input  logic             old_dst_en,
    input  logic [REG_W-1:0] old_dst,
    input  logic             old_flag_wr,
    input  logic [1:0]       old_lat,
    input  logic             yng_src_a_en,
    input  logic [REG_W-1:0] yng_src_a,
    input  logic             yng_src_b_en,
    input  logic [REG_W-1:0] yng_src_b,
    input  logic             yng_flag_rd,
    output logic             conflict
);

    logic reg_dep;
    logic flag_dep;
    logic has_delay;

    always_comb begin
        reg_dep   = old_dst_en && ((yng_src_a_en && (yng_src_a == old_dst))
                                || (yng_src_b_en && (yng_src_b == old_dst)));
        flag_dep  = old_flag_wr && yng_flag_rd;
        has_delay = (old_lat != 2'd0);
        conflict  = has_delay && (reg_dep || flag_dep);
    end

endmodule

// File: rtl/dual_issue_interlock.sv
module dual_issue_interlock #(
    parameter  int NUM_REGS = 16,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             old_valid,
    input  logic [REG_W-1:0] old_src_a,
    input  logic             old_src_a_en,
    input  logic [REG_W-1:0] old_src_b,
    input  logic             old_src_b_en,
    input  logic [REG_W-1:0] old_dst,
    input  logic             old_dst_en,
    input  logic             old_flag_rd,
    input  logic             old_flag_wr,
    input  logic [1:0]       old_lat,
    input  logic             yng_valid,
    input  logic [REG_W-1:0] yng_src_a,
    input  logic             yng_src_a_en,
    input  logic [REG_W-1:0] yng_src_b,
    input  logic             yng_src_b_en,
    input  logic [REG_W-1:0] yng_dst,
    input  logic             yng_dst_en,
    input  logic             yng_flag_rd,
    input  logic             yng_flag_wr,
    input  logic [1:0]       yng_lat,
    output logic             old_issue,
    output logic             yng_issue,
    output logic             stall
);

    localparam int NENT     = NUM_REGS + 1;
    localparam int FLAG_IDX = NUM_REGS;
    localparam int SLOTS    = 2;

    // slot 0 = older, slot 1 = younger
    logic [SLOTS-1:0][REG_W-1:0] s_src_a, s_src_b, s_dst;
    logic [SLOTS-1:0]            s_src_a_en, s_src_b_en, s_dst_en;
    logic [SLOTS-1:0]            s_flag_rd, s_flag_wr;
    logic [SLOTS-1:0]            s_hazard;
    logic [SLOTS-1:0]            s_issue;
    logic [SLOTS-1:0][NENT-1:0]  s_wmask;
    logic [NENT-1:0]             busy;
    logic                        pair_conflict;

    assign s_src_a    = {yng_src_a,    old_src_a};
    assign s_src_b    = {yng_src_b,    old_src_b};
    assign s_dst      = {yng_dst,      old_dst};
    assign s_src_a_en = {yng_src_a_en, old_src_a_en};
    assign s_src_b_en = {yng_src_b_en, old_src_b_en};
    assign s_dst_en   = {yng_dst_en,   old_dst_en};
    assign s_flag_rd  = {yng_flag_rd,  old_flag_rd};
    assign s_flag_wr  = {yng_flag_wr,  old_flag_wr};

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        dii_slot_hazard #(
            .NUM_REGS (NUM_REGS),
            .REG_W    (REG_W),
            .NENT     (NENT)
        ) u_haz (
            .src_a_en (s_src_a_en[s]),
            .src_a    (s_src_a[s]),
            .src_b_en (s_src_b_en[s]),
            .src_b    (s_src_b[s]),
            .dst_en   (s_dst_en[s]),
            .dst      (s_dst[s]),
            .flag_rd  (s_flag_rd[s]),
            .flag_wr  (s_flag_wr[s]),
            .busy     (busy),
            .hazard   (s_hazard[s])
        );

        for (genvar e = 0; e < NUM_REGS; e++) begin : g_reg_mask
            assign s_wmask[s][e] = s_issue[s] && s_dst_en[s] && (s_dst[s] == REG_W'(e));
        end
        assign s_wmask[s][FLAG_IDX] = s_issue[s] && s_flag_wr[s];
    end

    dii_pair_check #(
        .REG_W (REG_W)
    ) u_pair (
        .old_dst_en   (old_dst_en),
        .old_dst      (old_dst),
        .old_flag_wr  (old_flag_wr),
        .old_lat      (old_lat),
        .yng_src_a_en (yng_src_a_en),
        .yng_src_a    (yng_src_a),
        .yng_src_b_en (yng_src_b_en),
        .yng_src_b    (yng_src_b),
        .yng_flag_rd  (yng_flag_rd),
        .conflict     (pair_conflict)
    );

    always_comb begin
        s_issue[0] = !rst && old_valid && !s_hazard[0];
        s_issue[1] = s_issue[0] && yng_valid && !s_hazard[1] && !pair_conflict;
    end

    dii_scoreboard #(
        .NENT (NENT)
    ) u_sb (
        .clk         (clk),
        .rst         (rst),
        .wr_old_mask (s_wmask[0]),
        .wr_old_lat  (old_lat),
        .wr_yng_mask (s_wmask[1]),
        .wr_yng_lat  (yng_lat),
        .busy        (busy)
    );

    assign old_issue = s_issue[0];
    assign yng_issue = s_issue[1];
    assign stall     = (old_valid && !s_issue[0]) || (yng_valid && !s_issue[1]);

endmodule

// File: rtl/dii_checker.sv
module dii_checker #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst,
    input logic             old_valid,
    input logic             yng_valid,
    input logic [REG_W-1:0] old_src_a,
    input logic             old_src_a_en,
    input logic [REG_W-1:0] old_dst,
    input logic             old_dst_en,
    input logic             old_flag_wr,
    input logic [1:0]       old_lat,
    input logic [REG_W-1:0] yng_src_a,
    input logic             yng_src_a_en,
    input logic [REG_W-1:0] yng_dst,
    input logic             yng_dst_en,
    input logic             yng_flag_rd,
    input logic             old_issue,
    input logic             yng_issue,
    input logic             stall,
    input logic [NUM_REGS:0] busy
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |-> (!old_issue && !yng_issue));

    a_r1_sb_clear: assert property (@(posedge clk)
        rst |=> (busy == '0));

    a_r9_yng_needs_old: assert property (@(posedge clk) disable iff (rst)
        yng_issue |-> old_issue);

    a_r9_valid_only: assert property (@(posedge clk) disable iff (rst)
        (old_issue |-> old_valid) and (yng_issue |-> yng_valid));

    a_r10_stall_held: assert property (@(posedge clk) disable iff (rst)
        (old_valid && !old_issue) |-> stall);

    a_r10_stall_clear: assert property (@(posedge clk) disable iff (rst)
        (old_valid && yng_valid && old_issue && yng_issue) |-> !stall);

    a_r7_pair_reg: assert property (@(posedge clk) disable iff (rst)
        (yng_issue && old_lat != 2'd0 && old_dst_en) |-> !(yng_src_a_en && yng_src_a == old_dst));

    a_r7_pair_flag: assert property (@(posedge clk) disable iff (rst)
        (yng_issue && old_lat != 2'd0 && old_flag_wr) |-> !yng_flag_rd);

    // R2: the cycle after a load issues, a reader of its destination is held
    a_r2_load_use: assert property (@(posedge clk) disable iff (rst)
        ($past(old_issue && old_lat == 2'd2 && old_dst_en)
         && !$past(yng_issue && yng_dst_en && yng_dst == old_dst)
         && old_src_a_en && old_src_a == $past(old_dst)) |-> !old_issue);

endmodule

bind dual_issue_interlock dii_checker #(
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .old_valid    (old_valid),
    .yng_valid    (yng_valid),
    .old_src_a    (old_src_a),
    .old_src_a_en (old_src_a_en),
    .old_dst      (old_dst),
    .old_dst_en   (old_dst_en),
    .old_flag_wr  (old_flag_wr),
    .old_lat      (old_lat),
    .yng_src_a    (yng_src_a),
    .yng_src_a_en (yng_src_a_en),
    .yng_dst      (yng_dst),
    .yng_dst_en   (yng_dst_en),
    .yng_flag_rd  (yng_flag_rd),
    .old_issue    (old_issue),
    .yng_issue    (yng_issue),
    .stall        (stall),
    .busy         (busy)
);

// File: tb/tb_dual_issue_interlock.sv
`timescale 1ns/1ps
module tb_dual_issue_interlock;

    typedef struct packed {
        logic       v;
        logic [3:0] a;
        logic       ae;
        logic [3:0] b;
        logic       be;
        logic [3:0] d;
        logic       de;
        logic       fr;
        logic       fw;
        logic [1:0] lat;
    } ins_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    ins_t io, iy;
    logic old_issue, yng_issue, stall;

    int cnt[17];
    int ptr;
    int vecs = 0;
    int bad  = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_issue_interlock dut (
        .clk(clk), .rst(rst),
        .old_valid(io.v), .old_src_a(io.a), .old_src_a_en(io.ae),
        .old_src_b(io.b), .old_src_b_en(io.be), .old_dst(io.d), .old_dst_en(io.de),
        .old_flag_rd(io.fr), .old_flag_wr(io.fw), .old_lat(io.lat),
        .yng_valid(iy.v), .yng_src_a(iy.a), .yng_src_a_en(iy.ae),
        .yng_src_b(iy.b), .yng_src_b_en(iy.be), .yng_dst(iy.d), .yng_dst_en(iy.de),
        .yng_flag_rd(iy.fr), .yng_flag_wr(iy.fw), .yng_lat(iy.lat),
        .old_issue(old_issue), .yng_issue(yng_issue), .stall(stall)
    );

    function automatic ins_t gen(int mode, int k);
        ins_t i;
        logic [31:0] h;
        h = 32'(k) * 32'h9E3779B1 ^ (32'(mode) << 24);
        h = h ^ (h >> 13);
        h = h * 32'h85EBCA6B;
        h = h ^ (h >> 16);
        i = '0;
        i.v = 1'b1;
        case (mode)
            0: if (k % 2 == 0) begin        // load into r0..r3
                   i.a = 4'd8; i.ae = 1; i.d = 4'((k / 2) % 4); i.de = 1; i.lat = 2'd2;
               end else begin               // add that uses the load
                   i.a = 4'(((k - 1) / 2) % 4); i.ae = 1; i.d = 4'(4 + (k / 2) % 4); i.de = 1; i.lat = 2'd1;
               end
            1: if (k % 2 == 0) begin        // compare sets flag, zero latency
                   i.a = 4'd9; i.ae = 1; i.b = 4'd10; i.be = 1; i.fw = 1; i.lat = 2'd0;
               end else begin               // conditional branch reads flag
                   i.fr = 1; i.lat = 2'd1;
               end
            2: if (k % 2 == 0) begin        // move, zero latency
                   i.a = 4'd11; i.ae = 1; i.d = 4'((k / 2) % 4); i.de = 1; i.lat = 2'd0;
               end else begin               // add reading the moved register
                   i.a = 4'(((k - 1) / 2) % 4); i.ae = 1; i.b = 4'd12; i.be = 1; i.d = 4'd5; i.de = 1; i.lat = 2'd1;
               end
            3: begin                        // multiply chain on r2
                   i.a = 4'd2; i.ae = 1; i.b = 4'd3; i.be = 1; i.d = 4'd2; i.de = 1; i.lat = 2'd3;
               end
            4: begin                        // independent work
                   i.a = 4'd13; i.ae = 1; i.b = 4'd14; i.be = 1; i.d = 4'(k % 12); i.de = 1; i.lat = h[1:0];
               end
            6: case (k % 3)                 // same-destination pair then reader
                   0: begin i.a = 4'd13; i.ae = 1; i.d = 4'd6; i.de = 1; i.lat = 2'd3; end
                   1: begin i.a = 4'd13; i.ae = 1; i.d = 4'd6; i.de = 1; i.lat = 2'd0; end
                   default: begin i.a = 4'd6; i.ae = 1; i.d = 4'd7; i.de = 1; i.lat = 2'd1; end
               endcase
            default: begin                  // hashed operands over r0..r3
                   i.a = {2'b00, h[1:0]}; i.ae = h[2]; i.b = {2'b00, h[4:3]}; i.be = h[5];
                   i.d = {2'b00, h[7:6]}; i.de = h[8]; i.fr = h[9]; i.fw = h[10]; i.lat = h[12:11];
               end
        endcase
        return i;
    endfunction

    function automatic bit pend(int e);
        return cnt[e] != 0;
    endfunction

    function automatic bit src_haz(ins_t i);
        return (i.ae && pend(int'(i.a))) || (i.be && pend(int'(i.b))) || (i.fr && pend(16));
    endfunction

    function automatic bit dst_haz(ins_t i);
        return (i.de && pend(int'(i.d))) || (i.fw && pend(16));
    endfunction

    function automatic bit reads_older(ins_t o, ins_t y);
        return (o.de && ((y.ae && y.a == o.d) || (y.be && y.b == o.d))) || (o.fw && y.fr);
    endfunction

    task automatic seed(ins_t i);
        int s;
        s = (i.lat == 2'd0) ? 0 : int'(i.lat) - 1;
        if (i.de) cnt[int'(i.d)] = s;
        if (i.fw) cnt[16] = s;
    endtask

    task automatic check_cycle(string mtag, int cyc);
        bit eo, ey, es;
        string tag;
        eo = !rst && io.v && !src_haz(io) && !dst_haz(io);
        ey = eo && iy.v && !src_haz(iy) && !dst_haz(iy)
           && !(io.lat != 2'd0 && reads_older(io, iy));
        es = (io.v && !eo) || (iy.v && !ey);
        if (rst)                                   tag = "R1";
        else if (!io.v)                            tag = "R9";
        else if (src_haz(io))                      tag = "R3 R5";
        else if (dst_haz(io))                      tag = "R4 R5";
        else if (!iy.v)                            tag = "R9";
        else if (src_haz(iy) || dst_haz(iy))       tag = "R6";
        else if (reads_older(io, iy))              tag = (io.lat == 2'd0) ? "R8" : "R7";
        else                                       tag = "R2";
        vecs++;
        if ({old_issue, yng_issue, stall} !== {eo, ey, es}) begin
            bad++;
            $display("FAIL %s %s R10 cycle %0d: issue_o/issue_y/stall got %b%b%b expected %b%b%b",
                     mtag, tag, cyc, old_issue, yng_issue, stall, eo, ey, es);
        end
        // model next state
        if (rst) begin
            for (int e = 0; e < 17; e++) cnt[e] = 0;
        end else begin
            for (int e = 0; e < 17; e++) if (cnt[e] > 0) cnt[e] = cnt[e] - 1;
            if (eo) seed(io);
            if (ey) seed(iy);
            ptr = ptr + int'(eo) + int'(ey);
        end
    endtask

    task automatic run(int mode, string mtag, int n, int rst_at);
        ptr = 0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            rst = (c == rst_at);
            io  = gen(mode, ptr);
            iy  = gen(mode, ptr + 1);
            if (mode == 5 && c % 11 == 5) io.v = 1'b0;
            if (mode == 5 && c % 7 == 3)  iy.v = 1'b0;
            #2;
            check_cycle(mtag, c);
        end
    endtask

    initial begin
        io = '0; iy = '0;
        for (int e = 0; e < 17; e++) cnt[e] = 0;
        // reset phase with live requests: R1
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            rst = 1'b1;
            io = gen(5, c); iy = gen(5, c + 1);
            #2;
            check_cycle("R1 reset", c);
        end
        run(0, "R2 load-use",      400, 150);
        run(1, "R8 compare-branch", 300, 100);
        run(2, "R8 move-add",      300, 120);
        run(3, "R2 multiply",      400, 77);
        run(4, "R6 independent",   300, 200);
        run(6, "R11 same-dest",    300, 90);
        run(5, "R3 R4 random",    3000, 1234);
        run(5, "R9 random-tail",   500, 3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

endmodule